// File: doc/BRIEF.md
# Pixel Memory Refresh and Readout Sequencer

This block is the global controller for the storage inside each pixel of an image sensor array. Every pixel keeps three 6-bit values in three-transistor dynamic cells. Per bit, the three cells share one regenerating path and one data-line buffer. The sequencer has three jobs. It drives the strobes that regenerate each of the three memories in turn on a programmable interval. It reads one chosen memory onto the data line. It combines the global acquisition and transfer controls with each pixel's comparator output to make the local controls of that pixel.

Every visit to a memory follows the same fixed sequence, and each phase lasts a programmable number of cycles. First the shared node is precharged through the active-low precharge strobe. Next the output select of the chosen memory is raised. Last, the access select and the regenerate strobe are raised together with the output select. A readout follows the same sequence and also drives the data line in the last phase. A refresh may start while a pixel is acquiring. Memory 1 is then the acquisition target, so it is left out of that refresh pass. A refresh that falls due during a readout waits until the readout ends. A readout requested during a refresh waits in the same way.

The controller state machine has four states. ST_IDLE waits for work. ST_PRE precharges. ST_SEL enables the output select. ST_REGEN drives access plus regenerate. The transitions are:
- start: ST_IDLE→ST_PRE, when a refresh or a readout is pending. Refresh wins if both are pending.
- pre_done: ST_PRE→ST_SEL.
- sel_done: ST_SEL→ST_REGEN.
- next_mem: ST_REGEN→ST_PRE, during a refresh whose current memory is not memory 3.
- op_done: ST_REGEN→ST_IDLE.

Each of the *_done and next_mem transitions fires at the end of the phase's last cycle.

Top module: `pxmem_seq`

## Requirements
- R1: During reset and after reset, before any work, the outputs are: pch_n=1, osel=0, acc_sel=0, rfsh=0, out_en=0 and busy=0.
- R2: The refresh timer makes a refresh due every rf_period cycles, and the value 0 is treated as 1. If no readouts intervene and a refresh pass is shorter than the period, successive refresh passes start exactly rf_period cycles apart.
- R3: Let L = phase_len, with 0 treated as 1; L is captured when an operation starts. Each memory visit holds pch_n low for L cycles with osel=0. Then the one-hot osel (bit j-1 for memory j) alone is high for L cycles. Then rfsh and acc_sel, equal to osel, are high for L cycles.
- R4: With acquisition off, a refresh pass visits memories 1, 2 and 3 in that order. Each next precharge starts in the cycle right after the previous regenerate phase.
- R5: With acquisition on (acq_en=1) when a refresh pass starts, the pass visits only memories 2 and 3 and never strobes memory 1.
- R6: A readout request (rd_req high for one cycle) with rd_sel code 0, 1 or 2 visits only memory 1, 2 or 3 respectively, with out_en high exactly during its regenerate phase. Code 3 is ignored and leaves the block idle.
- R7: A refresh that falls due during a readout is kept pending. It starts after exactly one idle cycle following the readout's last regenerate cycle.
- R8: A readout requested during a refresh pass is kept pending. It starts after the pass, after exactly one idle cycle.
- R9: At most one bit of osel and at most one bit of acc_sel is high at any time, and osel is zero whenever pch_n is low.
- R10: With acq_en=1 the comparator steers each pixel: uncnd=0, pix_input=~cmp_trip, pix_si1=~cmp_trip and pix_enm=cmp_trip. This holds regardless of xfer_en.
- R11: With acq_en=0, uncnd=1 and the comparator is ignored. While the sequencer is idle, each pixel's local input, SI1 and ENM equal xfer_input, xfer_si1 and xfer_enm when xfer_en=1, and are all 0 when xfer_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_period | input | TW | Refresh interval in cycles (0 acts as 1) |
| phase_len | input | PW | Cycles per sequencer phase (0 acts as 1) |
| acq_en | input | 1 | Optical acquisition in progress |
| xfer_en | input | 1 | Image upload/download mode |
| xfer_input | input | 1 | Global input-buffer enable in transfer mode |
| xfer_si1 | input | 1 | Global memory-1 access in transfer mode |
| xfer_enm | input | 1 | Global memory-enable in transfer mode |
| rd_req | input | 1 | Readout request pulse |
| rd_sel | input | 2 | Memory code for readout (0..2; 3 ignored) |
| cmp_trip | input | NPIX | Per-pixel comparator outputs |
| pch_n | output | 1 | Active-low precharge strobe |
| osel | output | 3 | One-hot output select per memory |
| acc_sel | output | 3 | One-hot access select per memory |
| rfsh | output | 1 | Regenerate strobe |
| out_en | output | 1 | Drive stored bit onto external data line |
| busy | output | 1 | Sequencer is running an operation |
| uncnd | output | 1 | Forces comparator output to zero when high |
| pix_input | output | NPIX | Per-pixel local input-buffer enable |
| pix_si1 | output | NPIX | Per-pixel local memory-1 access |
| pix_enm | output | NPIX | Per-pixel local memory enable |

## Verification
The bench targets collisions between the timer and readouts. A design that drops a refresh that falls due mid-readout, or that starts it before the readout has finished, would show a missing or misplaced precharge after the readout. The bench also probes the edges of the phase length: zero must behave as one cycle, and a maximum length must not wrap the phase counter. It runs refresh passes during acquisition to catch a design that still strobes memory 1, which would show up as a third visit and a wrong period. Random comparator patterns in both modes expose gating that inverts the wrong control or lets the comparator act during transfers.

// File: rtl/pxmem_pkg.sv
package pxmem_pkg;
    localparam int NMEM = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_SEL,
        ST_REGEN
    } seq_state_t;
endpackage

// File: rtl/pxmem_tick.sv
module pxmem_tick #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period,
    input  logic          clr,
    output logic          pend
);
    logic [TW-1:0] cnt;
    logic          wrap;

    assign wrap = (period <= TW'(1)) ? 1'b1 : (cnt >= period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // A due refresh is never lost before it is taken
    assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/pxmem_fsm.sv
module pxmem_fsm
    import pxmem_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase_len,
    input  logic          acq_en,
    input  logic          rf_pend,
    input  logic          rd_req,
    input  logic [1:0]    rd_sel,
    output logic          rf_take,
    output logic          pch_n,
    output logic [NMEM-1:0] osel,
    output logic [NMEM-1:0] acc_sel,
    output logic          rfsh,
    output logic          out_en,
    output logic          busy
);
    seq_state_t    state_q, state_d;
    logic [1:0]    mem_q, mem_d;
    logic          op_rd_q, op_rd_d;
    logic [PW-1:0] len_q, len_d;
    logic [PW-1:0] ph_cnt, cnt_d;
    logic          rd_pend_q;
    logic [1:0]    rd_mem_q;
    logic          rd_take, rd_ok, ph_last;
    logic [PW-1:0] eff_len;

    assign eff_len = (phase_len == '0) ? PW'(1) : phase_len;
    assign ph_last = (ph_cnt == len_q - 1'b1);
    assign rf_take = (state_q == ST_IDLE) && rf_pend;
    assign rd_take = (state_q == ST_IDLE) && !rf_pend && rd_pend_q;
    assign rd_ok   = rd_req && (rd_sel != 2'd3) && !rd_pend_q && !(busy && op_rd_q);

    // pending readout request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_mem_q  <= '0;
        end else if (rd_take) begin
            rd_pend_q <= 1'b0;
        end else if (rd_ok) begin
            rd_pend_q <= 1'b1;
            rd_mem_q  <= rd_sel;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        mem_d   = mem_q;
        op_rd_d = op_rd_q;
        len_d   = len_q;
        cnt_d   = ph_cnt + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (rf_take) begin
                    state_d = ST_PRE;
                    mem_d   = acq_en ? 2'd1 : 2'd0;
                    op_rd_d = 1'b0;
                    len_d   = eff_len;
                end else if (rd_take) begin
                    state_d = ST_PRE;
                    mem_d   = rd_mem_q;
                    op_rd_d = 1'b1;
                    len_d   = eff_len;
                end
            end
            ST_PRE: if (ph_last) begin
                state_d = ST_SEL;
                cnt_d   = '0;
            end
            ST_SEL: if (ph_last) begin
                state_d = ST_REGEN;
                cnt_d   = '0;
            end
            ST_REGEN: if (ph_last) begin
                cnt_d = '0;
                if (!op_rd_q && mem_q != 2'd2) begin
                    state_d = ST_PRE;
                    mem_d   = mem_q + 2'd1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mem_q   <= '0;
            op_rd_q <= 1'b0;
            len_q   <= PW'(1);
            ph_cnt  <= '0;
        end else begin
            state_q <= state_d;
            mem_q   <= mem_d;
            op_rd_q <= op_rd_d;
            len_q   <= len_d;
            ph_cnt  <= cnt_d;
        end
    end

    // strobe outputs
    always_comb begin
        pch_n   = 1'b1;
        osel    = '0;
        acc_sel = '0;
        rfsh    = 1'b0;
        out_en  = 1'b0;
        busy    = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE:  pch_n = 1'b0;
            ST_SEL:  osel = NMEM'(3'b001 << mem_q);
            ST_REGEN: begin
                osel    = NMEM'(3'b001 << mem_q);
                acc_sel = NMEM'(3'b001 << mem_q);
                rfsh    = 1'b1;
                out_en  = op_rd_q;
            end
            default: ;
        endcase
    end

    assert_one_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(osel) && $onehot0(acc_sel) && !(!pch_n && (osel != '0)));

    assert_acc_in_regen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel != '0) |-> (acc_sel == osel) && rfsh && pch_n);

    assert_out_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (rfsh && op_rd_q));

    assert_skip_mem1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE && $past(state_q) == ST_IDLE && !op_rd_q && $past(acq_en))
        |-> (mem_q != 2'd0));

    assert_rf_after_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_REGEN && $past(op_rd_q) && rf_pend)
        |=> (state_q == ST_PRE && !op_rd_q));
endmodule

// File: rtl/pxmem_pixgate.sv
module pxmem_pixgate (
    input  logic uncnd,
    input  logic cmp,
    input  logic g_input,
    input  logic g_si1,
    input  logic g_enm,
    output logic l_input,
    output logic l_si1,
    output logic l_enm
);
    logic tripped;

    always_comb begin
        tripped = cmp & ~uncnd;
        l_input = g_input & ~tripped;
        l_si1   = g_si1 & ~tripped;
        l_enm   = g_enm | tripped;
    end
endmodule

// File: rtl/pxmem_seq.sv
module pxmem_seq
    import pxmem_pkg::*;
#(
    parameter int TW   = 16,
    parameter int PW   = 4,
    parameter int NPIX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   rf_period,
    input  logic [PW-1:0]   phase_len,
    input  logic            acq_en,
    input  logic            xfer_en,
    input  logic            xfer_input,
    input  logic            xfer_si1,
    input  logic            xfer_enm,
    input  logic            rd_req,
    input  logic [1:0]      rd_sel,
    input  logic [NPIX-1:0] cmp_trip,
    output logic            pch_n,
    output logic [2:0]      osel,
    output logic [2:0]      acc_sel,
    output logic            rfsh,
    output logic            out_en,
    output logic            busy,
    output logic            uncnd,
    output logic [NPIX-1:0] pix_input,
    output logic [NPIX-1:0] pix_si1,
    output logic [NPIX-1:0] pix_enm
);
    logic rf_pend, rf_take;
    logic g_input, g_si1, g_enm;

    pxmem_tick #(.TW(TW)) tick_i (
        .clk(clk), .rst_n(rst_n), .period(rf_period),
        .clr(rf_take), .pend(rf_pend)
    );

    pxmem_fsm #(.PW(PW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .phase_len(phase_len), .acq_en(acq_en),
        .rf_pend(rf_pend), .rd_req(rd_req), .rd_sel(rd_sel), .rf_take(rf_take),
        .pch_n(pch_n), .osel(osel), .acc_sel(acc_sel), .rfsh(rfsh),
        .out_en(out_en), .busy(busy)
    );

    // global controls; acquisition takes precedence over transfer
    always_comb begin
        uncnd   = !acq_en;
        g_input = acq_en | (xfer_en & xfer_input);
        g_si1   = acq_en | (xfer_en & xfer_si1) | acc_sel[0];
        g_enm   = !acq_en & xfer_en & xfer_enm;
    end

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pxmem_pixgate gate_i (
            .uncnd(uncnd), .cmp(cmp_trip[p]),
            .g_input(g_input), .g_si1(g_si1), .g_enm(g_enm),
            .l_input(pix_input[p]), .l_si1(pix_si1[p]), .l_enm(pix_enm[p])
        );
    end

    // a tripped pixel freezes: memory-1 access and memory enable never coexist
    assert_pix_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !uncnd |-> ((pix_si1 & pix_enm) == '0));
endmodule

// File: tb/pxmem_seq_tb_top.sv
`timescale 1ns/1ps
module pxmem_seq_tb_top;
    localparam int TW   = 16;
    localparam int PW   = 4;
    localparam int NPIX = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW-1:0]   rf_period = '0;
    logic [PW-1:0]   phase_len = '0;
    logic            acq_en = 1'b0, xfer_en = 1'b0;
    logic            xfer_input = 1'b0, xfer_si1 = 1'b0, xfer_enm = 1'b0;
    logic            rd_req = 1'b0;
    logic [1:0]      rd_sel = '0;
    logic [NPIX-1:0] cmp_trip = '0;
    logic            pch_n, rfsh, out_en, busy, uncnd;
    logic [2:0]      osel, acc_sel;
    logic [NPIX-1:0] pix_input, pix_si1, pix_enm;

    int checks = 0, fails = 0, cyc = 0, r9_bad = 0;
    int age [3];
    int maxage = 0;
    bit age_on = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pxmem_seq #(.TW(TW), .PW(PW), .NPIX(NPIX)) dut_i (
        .clk(clk), .rst_n(rst_n), .rf_period(rf_period), .phase_len(phase_len),
        .acq_en(acq_en), .xfer_en(xfer_en), .xfer_input(xfer_input),
        .xfer_si1(xfer_si1), .xfer_enm(xfer_enm), .rd_req(rd_req), .rd_sel(rd_sel),
        .cmp_trip(cmp_trip), .pch_n(pch_n), .osel(osel), .acc_sel(acc_sel),
        .rfsh(rfsh), .out_en(out_en), .busy(busy), .uncnd(uncnd),
        .pix_input(pix_input), .pix_si1(pix_si1), .pix_enm(pix_enm)
    );

    // R9 monitor and cell-retention model
    always @(negedge clk) begin
        if (rst_n) begin
            if (!$onehot0(osel) || !$onehot0(acc_sel) || (!pch_n && osel != 3'b000))
                r9_bad++;
            if (age_on) begin
                for (int j = 0; j < 3; j++) begin
                    if (rfsh && acc_sel[j]) age[j] = 0;
                    else age[j] = age[j] + 1;
                    if (age[j] > maxage) maxage = age[j];
                end
            end
        end
    end

    function automatic int eff(input int pl);
        return (pl == 0) ? 1 : pl;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input int per, input int pl);
        rst_n = 1'b0;
        rf_period = TW'(per);
        phase_len = PW'(pl);
        acq_en = 1'b0; xfer_en = 1'b0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_rd(input int s);
        rd_sel = 2'(s);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // observe one memory visit starting from the current sample
    task automatic observe(input int mem, input bit rd, input int L, input string tag,
                           output int gap, output int t0);
        int n, e;
        gap = 0;
        while (pch_n === 1'b1 && gap < 20000) begin gap++; @(negedge clk); end
        t0 = cyc;
        n = 0; e = 0;
        while (pch_n === 1'b0 && n < 100) begin
            if (osel != 3'b000) e++;
            n++; @(negedge clk);
        end
        chk(n == L && e == 0, {tag, " precharge phase"}, n, L);
        n = 0;
        while (osel == (3'b001 << mem) && !rfsh && n < 100) begin n++; @(negedge clk); end
        chk(n == L, {tag, " select phase memory"}, n, L);
        n = 0; e = 0;
        while (rfsh === 1'b1 && n < 100) begin
            if (acc_sel != osel || osel != (3'b001 << mem) || out_en != rd) e++;
            n++; @(negedge clk);
        end
        chk(n == L && e == 0, {tag, " regenerate phase"}, n + 1000 * e, L);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int g, ta, tb, L, s, pl, anyb;
        logic xi, xs, xe;
        void'($urandom(32'd2024));

        // R1: reset state
        rst_n = 1'b0;
        rf_period = TW'(3000);
        phase_len = PW'(2);
        repeat (2) @(negedge clk);
        chk(pch_n && osel == 0 && acc_sel == 0 && !rfsh && !out_en && !busy,
            "R1 outputs in reset", {pch_n, osel, acc_sel, rfsh, out_en, busy}, 10'h200);
        do_reset(3000, 2);
        chk(pch_n && osel == 0 && acc_sel == 0 && !rfsh && !out_en && !busy,
            "R1 outputs after reset", {pch_n, osel, acc_sel, rfsh, out_en, busy}, 10'h200);
        chk(uncnd && pix_input == 0 && pix_si1 == 0 && pix_enm == 0,
            "R11 idle locals zero", {pix_input, pix_si1, pix_enm}, 0);

        // R11: transfer mode follows globals, comparator ignored
        for (int i = 0; i < 8; i++) begin
            xfer_en = 1'b1;
            xi = 1'($urandom); xs = 1'($urandom); xe = 1'($urandom);
            xfer_input = xi; xfer_si1 = xs; xfer_enm = xe;
            cmp_trip = NPIX'($urandom);
            @(negedge clk);
            chk(uncnd && pix_input == {NPIX{xi}} && pix_si1 == {NPIX{xs}} && pix_enm == {NPIX{xe}},
                "R11 transfer locals", {pix_input, pix_si1, pix_enm}, {{NPIX{xi}}, {NPIX{xs}}, {NPIX{xe}}});
        end

        // R10: acquisition gating, also with transfer mode asserted
        acq_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cmp_trip = NPIX'($urandom);
            xfer_enm = 1'($urandom);
            @(negedge clk);
            chk(!uncnd && pix_input == ~cmp_trip && pix_si1 == ~cmp_trip && pix_enm == cmp_trip,
                "R10 acquisition locals", {pix_input, pix_si1, pix_enm},
                {~cmp_trip, ~cmp_trip, cmp_trip});
        end
        acq_en = 1'b0; xfer_en = 1'b0;

        // R6: code 3 ignored
        pulse_rd(3);
        anyb = 0;
        for (int i = 0; i < 20; i++) begin if (busy || !pch_n) anyb++; @(negedge clk); end
        chk(anyb == 0, "R6 code 3 ignored", anyb, 0);

        // R6/R3: random readouts
        for (int i = 0; i < 6; i++) begin
            s = $urandom % 3;
            pl = $urandom % 7;
            phase_len = PW'(pl);
            pulse_rd(s);
            observe(s, 1'b1, eff(pl), "R6 R3 readout", g, ta);
            chk(!busy || !pch_n, "R6 readout visits one memory", osel, 0);
            repeat (3) @(negedge clk);
        end

        // R2/R3/R4: periodic refresh passes
        do_reset(200, 2);
        observe(0, 1'b0, 2, "R4 memory 1", g, ta);
        observe(1, 1'b0, 2, "R4 memory 2", g, tb);
        chk(g == 0, "R4 back-to-back 1->2", g, 0);
        observe(2, 1'b0, 2, "R4 memory 3", g, tb);
        chk(g == 0, "R4 back-to-back 2->3", g, 0);
        #1; maxage = 0; age_on = 1'b1;
        for (int k = 0; k < 3; k++) begin
            observe(0, 1'b0, 2, "R2 pass", g, tb);
            chk(tb - ta == 200, "R2 refresh interval", tb - ta, 200);
            ta = tb;
            observe(1, 1'b0, 2, "R4 memory 2", g, tb);
            observe(2, 1'b0, 2, "R4 memory 3", g, tb);
        end
        chk(maxage <= 200, "R2 cell retention age", maxage, 200);
        age_on = 1'b0;

        // R3 boundaries: 0 acts as 1, maximum length
        do_reset(300, 0);
        for (int m = 0; m < 3; m++) observe(m, 1'b0, 1, "R3 length zero", g, tb);
        do_reset(400, 15);
        for (int m = 0; m < 3; m++) observe(m, 1'b0, 15, "R3 length max", g, tb);

        // R5: refresh during acquisition skips memory 1
        do_reset(150, 2);
        acq_en = 1'b1;
        cmp_trip = NPIX'($urandom);
        observe(1, 1'b0, 2, "R5 first visit memory 2", g, ta);
        observe(2, 1'b0, 2, "R5 then memory 3", g, tb);
        observe(1, 1'b0, 2, "R5 next pass memory 2", g, tb);
        chk(tb - ta == 150, "R5 no memory-1 visit in pass", tb - ta, 150);
        acq_en = 1'b0;

        // R7: refresh due during readout waits one idle cycle after it
        do_reset(100, 5);
        repeat (87) @(negedge clk);
        pulse_rd(1);
        observe(1, 1'b1, 5, "R7 readout", g, ta);
        observe(0, 1'b0, 5, "R7 deferred refresh", g, tb);
        chk(g == 1, "R7 gap after readout", g, 1);
        observe(1, 1'b0, 5, "R7 memory 2", g, tb);
        observe(2, 1'b0, 5, "R7 memory 3", g, tb);

        // R8: readout requested mid-refresh waits for the pass
        do_reset(100, 2);
        g = 0;
        while (osel != 3'b001 && g < 1000) begin g++; @(negedge clk); end
        pulse_rd(2);
        observe(1, 1'b0, 2, "R8 refresh continues memory 2", g, tb);
        observe(2, 1'b0, 2, "R8 refresh continues memory 3", g, tb);
        observe(2, 1'b1, 2, "R8 deferred readout", g, tb);
        chk(g == 1, "R8 gap after refresh", g, 1);

        chk(r9_bad == 0, "R9 select exclusivity", r9_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule